// File: doc/BRIEF.md
# Lockable Watchdog with Reset-Cause Flags

This block is a fail-safe timer for a processor subsystem. A 16-bit up-counter advances once per prescaled tick, where the tick comes from the system clock divided by 2 or by 128. When the counter rolls over from all ones, the block requests a reset for a fixed number of cycles. Software keeps the counter away from rollover by rewriting the control register and then pulsing the service input. A service that takes effect reloads the counter's upper byte from a reload register and clears its lower byte. This means the reload value alone sets the timeout length.

The watchdog is running whenever any reset has just been released. Start-up code may switch it off through the control register, but only until it signals end of initialization. From that strobe onward the timer is forced on and any disable request is ignored. A three-bit cause register records which sources have reset the system: hardware, software or watchdog overflow. It keeps those marks through later resets, so start-up code can read them. The end-of-initialization strobe clears it, and a power-on reset returns it to its power-on value.

Top module: `wdg_top`

## Requirements
- R1: After any reset (power-on, hardware, software or watchdog), the counter starts from zero with divide-by-2 selected, so the first overflow comes 2·2^CNT_W clock edges after the last reset edge.
- R2: Control register (write select 0) bit 0 picks the prescaler. 0 divides the clock by DIV_FAST (2), and 1 divides it by DIV_SLOW (128).
- R3: A service that takes effect loads the counter with {reload, zeros} and clears the prescaler. Overflow then follows after (2^CNT_W − reload·2^(CNT_W−RELOAD_W)) ticks: 256 ticks for reload FFh and 65536 ticks for 00h at default widths.
- R4: A service pulse takes effect only if the control register was written since the previous effective service or reset. Otherwise it has no effect on the timeout.
- R5: Writing the control register with bit 1 set, before end of initialization, stops the counter and prescaler. Writing bit 1 clear restarts them from where they stopped.
- R6: The end-of-initialization strobe forces the watchdog on and locks it. After the strobe, a disable request is ignored until the next reset.
- R7: On overflow, rst_n_o goes low and rst_req_o goes high on the clock edge of the overflowing tick. Both stay in that state for exactly HOLD_LEN (16) cycles.
- R8: cause_o bit 0 marks a hardware or power-on reset, bit 1 marks a software reset, and bit 2 marks a watchdog overflow. Each bit is set by its source and is kept through the other resets.
- R9: The end-of-initialization strobe clears cause_o to 000. A power-on reset sets it to 001.
- R10: An overflow returns the block to its reset configuration: divide-by-2, reload value 0, enabled, unlocked, and service not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| por_i | input | 1 | Synchronous active-high power-on reset |
| sw_rst_i | input | 1 | Software reset strobe |
| eoi_i | input | 1 | End-of-initialization strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 reload |
| wr_data_i | input | 8 | Write data; control uses bit 0 (slow) and bit 1 (disable) |
| srv_i | input | 1 | Service pulse |
| rst_req_o | output | 1 | Internal reset request, high during the hold |
| rst_n_o | output | 1 | Active-low reset output |
| cause_o | output | 3 | Reset cause flags {watchdog, software, hardware} |

## Verification
The assertions assume the following about the block's inputs:
- Every reset input is synchronous to the clock.
- Power-on reset is asserted from time zero.
- HOLD_LEN is at least two.
- DIV_SLOW is at least DIV_FAST.

The stimulus keeps within these limits. It starts under power-on reset and changes every input only at the falling clock edge. It raises at most one strobe per write, service or reset action. The bench uses a reduced configuration (10-bit counter, 4-bit reload, dividers 2 and 4) so that every reload value can be swept under both prescaler settings, with each timeout predicted from the R3 formula.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int HOLD_CYC = 16;

    typedef struct packed {
        logic dis;
        logic slow;
    } ctrl_t;

    typedef struct packed {
        logic wdt;
        logic sw;
        logic hw;
    } cause_t;

    localparam cause_t CAUSE_POR = '{wdt: 1'b0, sw: 1'b0, hw: 1'b1};

    typedef enum logic {
        REG_CTRL   = 1'b0,
        REG_RELOAD = 1'b1
    } reg_sel_e;

    function automatic ctrl_t decode_ctrl(input logic [7:0] d);
        ctrl_t c;
        c.dis  = d[1];
        c.slow = d[0];
        return c;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    assign limit = slow ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
    assign tick  = run && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (clr)
            pre_q <= '0;
        else if (run)
            pre_q <= tick ? '0 : pre_q + 1'b1;
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W    = 16,
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                init,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                step,
    output logic                wrap
);
    localparam int LO_W = CNT_W - RELOAD_W;

    logic [CNT_W-1:0] cnt_q;

    assign wrap = step && (&cnt_q);

    always_ff @(posedge clk) begin
        if (init)
            cnt_q <= '0;
        else if (load)
            cnt_q <= {reload, {LO_W{1'b0}}};
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_LOAD_SHAPE: assert property (@(posedge clk) disable iff (init)
        (load && !init) |=> (cnt_q == {$past(reload), {LO_W{1'b0}}})); // R3

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (init)
        (!step && !load && !init) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/wdg_cause.sv
module wdg_cause
    import wdg_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  logic   hw_set,
    input  logic   sw_set,
    input  logic   wdt_set,
    input  logic   eoi,
    output cause_t cause
);
    cause_t nxt;

    always_comb begin
        nxt     = eoi ? '0 : cause;
        nxt.hw  = nxt.hw  | hw_set;
        nxt.sw  = nxt.sw  | sw_set;
        nxt.wdt = nxt.wdt | wdt_set;
    end

    always_ff @(posedge clk) begin
        if (por)
            cause <= CAUSE_POR;
        else
            cause <= nxt;
    end

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (por)
        (eoi && !hw_set && !sw_set && !wdt_set) |=> (cause == '0)); // R9

    AST_WDT_STICKY: assert property (@(posedge clk) disable iff (por)
        (cause.wdt && !eoi) |=> cause.wdt); // R8

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RELOAD_W = 8,
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 128,
    parameter int HOLD_LEN = HOLD_CYC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_i,
    input  logic       sw_rst_i,
    input  logic       eoi_i,
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic       srv_i,
    output logic       rst_req_o,
    output logic       rst_n_o,
    output logic [2:0] cause_o
);
    localparam int HOLD_W = $clog2(HOLD_LEN + 1);

    logic                ext_init, init, wrap, tick, run, srv_ok;
    logic                ctrl_wr, reload_wr;
    ctrl_t               wr_ctrl;
    logic                en_q, lock_q, armed_q, slow_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [HOLD_W-1:0]   hold_q;
    cause_t              cause;

    assign ext_init  = por_i | rst | sw_rst_i;
    assign init      = ext_init | wrap;
    assign wr_ctrl   = decode_ctrl(wr_data_i);
    assign ctrl_wr   = wr_en_i && (reg_sel_e'(wr_sel_i) == REG_CTRL);
    assign reload_wr = wr_en_i && (reg_sel_e'(wr_sel_i) == REG_RELOAD);
    assign run       = en_q && (hold_q == '0);
    assign srv_ok    = srv_i && armed_q && !init;

    always_ff @(posedge clk) begin
        if (init) begin
            en_q     <= 1'b1;
            lock_q   <= 1'b0;
            armed_q  <= 1'b0;
            slow_q   <= 1'b0;
            reload_q <= '0;
        end else begin
            if (eoi_i) begin
                en_q   <= 1'b1;
                lock_q <= 1'b1;
            end else if (ctrl_wr && !lock_q) begin
                en_q   <= !wr_ctrl.dis;
            end
            if (ctrl_wr)
                slow_q <= wr_ctrl.slow;
            if (reload_wr)
                reload_q <= wr_data_i[RELOAD_W-1:0];
            if (ctrl_wr)
                armed_q <= 1'b1;
            else if (srv_ok)
                armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (ext_init)
            hold_q <= '0;
        else if (wrap)
            hold_q <= HOLD_W'(HOLD_LEN);
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign rst_req_o = (hold_q != '0);
    assign rst_n_o   = (hold_q == '0);
    assign cause_o   = cause;

    wdg_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk  (clk),
        .clr  (init | srv_ok),
        .run  (run),
        .slow (slow_q),
        .tick (tick)
    );

    wdg_counter #(
        .CNT_W    (CNT_W),
        .RELOAD_W (RELOAD_W)
    ) u_cnt (
        .clk    (clk),
        .init   (init),
        .load   (srv_ok),
        .reload (reload_q),
        .step   (tick),
        .wrap   (wrap)
    );

    wdg_cause u_cause (
        .clk     (clk),
        .por     (por_i),
        .hw_set  (rst),
        .sw_set  (sw_rst_i),
        .wdt_set (wrap),
        .eoi     (eoi_i),
        .cause   (cause)
    );

    AST_LOCK_KEEPS_ON: assert property (@(posedge clk) disable iff (ext_init)
        lock_q |=> en_q); // R6

    AST_HOLD_NOT_SHORT: assert property (@(posedge clk) disable iff (ext_init)
        $fell(rst_n_o) |=> !rst_n_o); // R7

    AST_FLAG_WITH_PIN: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_n_o) |-> cause_o[2]); // R8

endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW   = 10;
    localparam int RW   = 4;
    localparam int DF   = 2;
    localparam int DS   = 4;
    localparam int FULL = 1 << CW;
    localparam int STEP = 1 << (CW - RW);
    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b0, por_i = 1'b1, sw_rst_i = 1'b0, eoi_i = 1'b0;
    logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, srv_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rst_req_o, rst_n_o;
    logic [2:0] cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdg_top #(
        .CNT_W(CW), .RELOAD_W(RW), .DIV_FAST(DF), .DIV_SLOW(DS), .HOLD_LEN(HOLD)
    ) u0 (
        .clk(clk), .rst(rst), .por_i(por_i), .sw_rst_i(sw_rst_i), .eoi_i(eoi_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .srv_i(srv_i),
        .rst_req_o(rst_req_o), .rst_n_o(rst_n_o), .cause_o(cause_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic service();
        srv_i = 1'b1;
        @(posedge clk); @(negedge clk);
        srv_i = 1'b0;
    endtask

    task automatic end_init();
        eoi_i = 1'b1;
        @(posedge clk); @(negedge clk);
        eoi_i = 1'b0;
    endtask

    task automatic expect_fall(input int n, input string tag);
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        check(tag, rst_n_o, 1'b1);
        @(posedge clk); @(negedge clk);
        check(tag, rst_n_o, 1'b0);
        check("R7", rst_req_o, 1'b1);
    endtask

    task automatic expect_hold();
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk);
        check("R7", rst_n_o, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R7", rst_n_o, 1'b1);
        check("R7", rst_req_o, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_i = 1'b0;
        check("R9", cause_o, 3'b001);
        check("R7", rst_n_o, 1'b1);
        check("R7", rst_req_o, 1'b0);

        // R1: default timeout after power-on reset
        expect_fall(FULL * DF, "R1");
        check("R8", cause_o, 3'b101);
        expect_hold();

        // R2 and R3: every reload value under both prescalers
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < (1 << RW); r++) begin
                wr(1'b1, 8'(r));
                wr(1'b0, {7'b0, s[0]});
                service();
                expect_fall((FULL - r * STEP) * (s != 0 ? DS : DF), s != 0 ? "R2" : "R3");
                check("R8", cause_o[2], 1'b1);
                expect_hold();
            end
        end

        // R10: overflow restores divide-by-2 and counter zero
        expect_fall(FULL * DF, "R10");
        expect_hold();
        // R10: reload value back to zero
        wr(1'b0, 8'h00);
        service();
        expect_fall(FULL * DF, "R10");
        expect_hold();

        // R4: service without a control write in between is ignored
        wr(1'b1, 8'h08);
        wr(1'b0, 8'h00);
        service();
        repeat (300) @(posedge clk);
        @(negedge clk);
        service();
        expect_fall((FULL - 8 * STEP) * DF - 301, "R4");
        expect_hold();

        // R5: disable before end of initialization freezes the count
        wr(1'b0, 8'h02);
        repeat (3000) @(posedge clk);
        @(negedge clk);
        check("R5", rst_n_o, 1'b1);
        wr(1'b0, 8'h00);
        expect_fall(FULL * DF - 1, "R5");
        expect_hold();

        // R6: end of initialization re-enables and locks
        wr(1'b0, 8'h02);
        end_init();
        check("R9", cause_o, 3'b000);
        wr(1'b0, 8'h02);
        expect_fall(FULL * DF - 2, "R6");
        check("R8", cause_o, 3'b100);
        expect_hold();

        // R8: software and hardware reset marks accumulate
        sw_rst_i = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_rst_i = 1'b0;
        check("R8", cause_o, 3'b110);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R8", cause_o, 3'b111);
        // R9: power-on reset restores the power-on value
        por_i = 1'b1;
        @(posedge clk); @(negedge clk);
        por_i = 1'b0;
        check("R9", cause_o, 3'b001);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule